// File: doc/BRIEF.md
# Instruction Cache with Fill Buffers

This block is the instruction-fetch front end of a small processor core. A lookup checks a set-associative tag store, where every way of the indexed set is compared at once, and checks two line-sized fetch buffers in the same cycle. Either kind of hit returns the instruction word combinationally, in the cycle the core presents the request. A fetch that finds its word in neither place is a miss. It claims a free fetch buffer and sends a line request to memory. Memory then returns the eight words of the line one at a time, each tagged with its buffer and its word index.

Each buffer tracks which of its words have arrived, so the core is released as soon as its own word is present. It does not wait for the whole line. Two misses may be in flight at once; a third waits until one buffer has retired its line. A finished line is copied into the cache only when it was marked cacheable at miss time and the cache is enabled. The victim way is picked by a round-robin pointer that each set keeps. A flush input empties the cache and both buffers in a single cycle.

Top module: `ifb_icache`

## Requirements
- R1: After reset the cache and both buffers hold nothing. With no request, `rsp_ready` and `mem_req_valid` are low, and the first fetch of any address is a miss.
- R2: A byte address splits into three fields. The word index is bits [4:2], the set index is bits [9:5] and the tag is bits [31:10]. A line request carries `mem_req_line` = address bits [31:5], and `mem_req_word` = bits [4:2] names the word memory returns first.
- R3: A miss raises `mem_req_valid` for one cycle, in the cycle of the miss, together with a buffer id. A fetch whose line is already being filled issues no new request, and neither does a hit.
- R4: A word returned by memory becomes available to the core from the next cycle, while other words of the same line are still outstanding. A word of that line that has not yet arrived gives `rsp_ready` low.
- R5: A fetch that hits the cache or a buffer word gives `rsp_ready` high, with the word on `rsp_data`, in the same cycle.
- R6: Two misses to different lines may be outstanding at once, and each uses a different buffer id.
- R7: A miss that arrives while both buffers are filling makes no request and is not served. Once a buffer has received all eight words and retired, the same fetch issues its request on the freed buffer.
- R8: A completed line is written into the cache when it is cacheable and the cache is enabled. A line is cacheable when `req_cacheable` was high at miss time or `mmu_en` was low. The written line then hits after both buffers have been reused.
- R9: A line fetched with `mmu_en` high and `req_cacheable` low is never written into the cache. It misses again once both buffers have been reused.
- R10: While `cache_en` is low, lines already in the cache still hit, buffer words still hit for forward and backward fetches with no memory request, and no completed line is written into the cache.
- R11: Each set replaces ways in round-robin order starting at way 0. With four ways, a fifth distinct line written into a set evicts the first one and keeps the second and third.
- R12: A one-cycle `flush` pulse invalidates every cache line and every buffer line. A fetch in the following cycle misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Enables writing completed lines into the cache |
| mmu_en | input | 1 | When low, every line counts as cacheable |
| flush | input | 1 | Invalidate cache and buffers |
| req_valid | input | 1 | Core fetch request present |
| req_addr | input | 32 | Fetch byte address |
| req_cacheable | input | 1 | Page cacheable attribute of the fetch |
| rsp_ready | output | 1 | Word returned this cycle |
| rsp_data | output | 32 | Returned instruction word |
| mem_req_valid | output | 1 | Line request to memory |
| mem_req_line | output | 27 | Line address of the request |
| mem_req_word | output | 3 | Word index memory returns first |
| mem_req_buf | output | 1 | Buffer id the line fills |
| mem_rsp_valid | input | 1 | Memory word present |
| mem_rsp_buf | input | 1 | Buffer id of the word |
| mem_rsp_idx | input | 3 | Word index within the line |
| mem_rsp_data | input | 32 | Returned word |

## Verification
A bad valid bit in a tag way or a buffer shows up the next time that address is fetched. It can appear as a wrong `rsp_ready` in the cycle of the request, or as a memory request that should not be there. A round-robin pointer that drifts, or a completion that skips its cache write, only becomes visible after both buffers have been reused. For that reason the scenarios deliberately push two further lines through the buffers before they probe the cache again. Errors in the buffer-id choice or the outstanding count show up as missing or misdirected requests within one cycle of the third miss.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 8;
    localparam int WIDX_W     = $clog2(LINE_WORDS);
    localparam int OFF_W      = WIDX_W + 2;
    localparam int LINE_BITS  = LINE_WORDS * WORD_W;

    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/ifb_tag_store.sv
module ifb_tag_store
    import ifb_pkg::*;
#(
    parameter int SETS  = 32,
    parameter int WAYS  = 4,
    parameter int TAG_W = 22,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [WAY_W-1:0] lk_way,
    input  logic [SET_W-1:0] ck_set,
    input  logic [TAG_W-1:0] ck_tag,
    output logic             ck_hit,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [TAG_W-1:0] wr_tag,
    output logic [WAY_W-1:0] wr_way
);
    logic [WAYS-1:0]  vld_d [SETS];
    logic [WAYS-1:0]  vld_q [SETS];
    logic [TAG_W-1:0] tag_d [SETS][WAYS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAY_W-1:0] rr_d  [SETS];
    logic [WAY_W-1:0] rr_q  [SETS];

    // parallel compare of every way in the indexed set
    always_comb begin
        lk_hit = 1'b0;
        lk_way = '0;
        ck_hit = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld_q[lk_set][w] && tag_q[lk_set][w] == lk_tag) begin
                lk_hit = 1'b1;
                lk_way = WAY_W'(w);
            end
            if (vld_q[ck_set][w] && tag_q[ck_set][w] == ck_tag) ck_hit = 1'b1;
        end
        wr_way = rr_q[wr_set];
    end

    always_comb begin
        vld_d = vld_q;
        tag_d = tag_q;
        rr_d  = rr_q;
        if (flush) begin
            for (int s = 0; s < SETS; s++) vld_d[s] = '0;
        end else if (wr_en) begin
            vld_d[wr_set][rr_q[wr_set]] = 1'b1;
            tag_d[wr_set][rr_q[wr_set]] = wr_tag;
            rr_d[wr_set] = (rr_q[wr_set] == WAY_W'(WAYS - 1)) ? '0 : rr_q[wr_set] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                rr_q[s]  <= '0;
                for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
            end
        end else begin
            vld_q <= vld_d;
            tag_q <= tag_d;
            rr_q  <= rr_d;
        end
    end
endmodule

// File: rtl/ifb_data_store.sv
module ifb_data_store
    import ifb_pkg::*;
#(
    parameter int ENTRIES = 128,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [LINE_BITS-1:0] wr_line,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic [WIDX_W-1:0]    rd_word,
    output word_t                rd_data
);
    word_t mem [ENTRIES][LINE_WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < LINE_WORDS; k++) mem[wr_idx][k] <= wr_line[k*WORD_W +: WORD_W];
        end
    end

    assign rd_data = mem[rd_idx][rd_word];
endmodule

// File: rtl/ifb_fill_buf.sv
module ifb_fill_buf
    import ifb_pkg::*;
#(
    parameter int LINE_W = 27
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  alloc,
    input  logic [LINE_W-1:0]     alloc_line,
    input  logic                  alloc_cach,
    input  logic                  wr_en,
    input  logic [WIDX_W-1:0]     wr_idx,
    input  word_t                 wr_data,
    output logic                  pending,
    output logic                  lvalid,
    output logic [LINE_W-1:0]     line,
    output logic [LINE_WORDS-1:0] wvalid,
    output logic [LINE_BITS-1:0]  words,
    output logic                  cach,
    output logic                  done
);
    typedef struct packed {
        logic                  pend;
        logic                  lv;
        logic [LINE_W-1:0]     line;
        logic [LINE_WORDS-1:0] wv;
        logic [LINE_BITS-1:0]  data;
        logic                  cach;
        logic [WIDX_W:0]       cnt;
    } buf_st_t;

    buf_st_t st_d, st_q;
    logic    done_w;

    assign done_w = st_q.pend && (st_q.cnt == (WIDX_W + 1)'(LINE_WORDS));

    always_comb begin
        st_d = st_q;
        if (alloc) begin
            st_d.pend = 1'b1;
            st_d.lv   = 1'b1;
            st_d.line = alloc_line;
            st_d.cach = alloc_cach;
            st_d.wv   = '0;
            st_d.cnt  = '0;
        end else begin
            if (wr_en && st_q.pend) begin
                st_d.wv[wr_idx] = 1'b1;
                st_d.data[wr_idx*WORD_W +: WORD_W] = wr_data;
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (done_w) st_d.pend = 1'b0;
        end
        // a flushed fill keeps counting words but never becomes visible
        if (flush) begin
            st_d.lv = 1'b0;
            st_d.wv = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = st_q.pend;
    assign lvalid  = st_q.lv;
    assign line    = st_q.line;
    assign wvalid  = st_q.wv;
    assign words   = st_q.data;
    assign cach    = st_q.cach;
    assign done    = done_w;
endmodule

// File: rtl/ifb_icache.sv
module ifb_icache
    import ifb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SETS   = 32,
    parameter int WAYS   = 4,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int TAG_W  = LINE_W - SET_W,
    localparam int NBUF   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              mmu_en,
    input  logic              flush,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_cacheable,
    output logic              rsp_ready,
    output logic [WORD_W-1:0] rsp_data,
    output logic              mem_req_valid,
    output logic [LINE_W-1:0] mem_req_line,
    output logic [WIDX_W-1:0] mem_req_word,
    output logic              mem_req_buf,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_buf,
    input  logic [WIDX_W-1:0] mem_rsp_idx,
    input  logic [WORD_W-1:0] mem_rsp_data
);
    typedef struct packed {
        logic rr;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [LINE_W-1:0] req_line;
    logic [WIDX_W-1:0] req_word;
    logic [SET_W-1:0]  req_set;
    logic [TAG_W-1:0]  req_tag;

    assign req_line = req_addr[ADDR_W-1:OFF_W];
    assign req_word = req_addr[OFF_W-1:2];
    assign req_set  = req_line[SET_W-1:0];
    assign req_tag  = req_line[LINE_W-1:SET_W];

    logic [NBUF-1:0]       pend, lv, bcach, bdone, bhit, bwait, alloc_b, wr_b;
    logic [LINE_W-1:0]     bline  [NBUF];
    logic [LINE_WORDS-1:0] bwv    [NBUF];
    logic [LINE_BITS-1:0]  bwords [NBUF];

    logic              alloc, sel, miss, cache_hit, ck_hit, csel, cw_en;
    logic [WAY_W-1:0]  lk_way, wr_way;
    logic [LINE_W-1:0] cline;
    word_t             cdata;

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        assign alloc_b[b] = alloc && (sel == 1'(b));
        assign wr_b[b]    = mem_rsp_valid && (mem_rsp_buf == 1'(b));
        assign bhit[b]    = lv[b] && bline[b] == req_line && bwv[b][req_word];
        assign bwait[b]   = lv[b] && pend[b] && bline[b] == req_line;

        ifb_fill_buf #(.LINE_W(LINE_W)) buf_i (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .alloc(alloc_b[b]), .alloc_line(req_line),
            .alloc_cach(req_cacheable || !mmu_en),
            .wr_en(wr_b[b]), .wr_idx(mem_rsp_idx), .wr_data(mem_rsp_data),
            .pending(pend[b]), .lvalid(lv[b]), .line(bline[b]), .wvalid(bwv[b]),
            .words(bwords[b]), .cach(bcach[b]), .done(bdone[b])
        );
    end

    ifb_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) tags_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_set(req_set), .lk_tag(req_tag), .lk_hit(cache_hit), .lk_way(lk_way),
        .ck_set(cline[SET_W-1:0]), .ck_tag(cline[LINE_W-1:SET_W]), .ck_hit(ck_hit),
        .wr_en(cw_en), .wr_set(cline[SET_W-1:0]), .wr_tag(cline[LINE_W-1:SET_W]),
        .wr_way(wr_way)
    );

    ifb_data_store #(.ENTRIES(SETS * WAYS)) data_i (
        .clk(clk), .wr_en(cw_en), .wr_idx({cline[SET_W-1:0], wr_way}),
        .wr_line(bwords[csel]), .rd_idx({req_set, lk_way}), .rd_word(req_word),
        .rd_data(cdata)
    );

    always_comb begin
        st_d = st_q;

        // lookup and delivery
        rsp_ready = req_valid && (cache_hit || (|bhit));
        if (cache_hit)    rsp_data = cdata;
        else if (bhit[0]) rsp_data = bwords[0][req_word*WORD_W +: WORD_W];
        else              rsp_data = bwords[1][req_word*WORD_W +: WORD_W];

        // miss handling: a line already filling is waited on, not re-requested
        miss  = req_valid && !cache_hit && !(|bhit) && !(|bwait) && !flush;
        sel   = (!pend[0] && !pend[1]) ? st_q.rr : !pend[1];
        alloc = miss && !(&pend);
        if (alloc) st_d.rr = !sel;

        // retire: at most one buffer completes in a cycle
        csel  = bdone[1] && !bdone[0];
        cline = bline[csel];
        cw_en = bdone[csel] && lv[csel] && bcach[csel] && cache_en && !ck_hit && !flush;

        mem_req_valid = alloc;
        mem_req_line  = req_line;
        mem_req_word  = req_word;
        mem_req_buf   = sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ifb_icache_chk.sv
module ifb_icache_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       rsp_ready,
    input logic       mem_req_valid,
    input logic       flush,
    input logic       cache_en,
    input logic       cw_en,
    input logic [1:0] pend
);
    a_r5_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> req_valid);

    a_r3_no_req_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !rsp_ready);

    a_r7_max_two: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !(&pend));

    a_r10_no_fill_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !cache_en |-> !cw_en);

    a_r12_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !rsp_ready);
endmodule

bind ifb_icache ifb_icache_chk chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_ready(rsp_ready),
    .mem_req_valid(mem_req_valid), .flush(flush), .cache_en(cache_en),
    .cw_en(cw_en), .pend(pend)
);

// File: tb/ifb_icache_tb_top.sv
module ifb_icache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n, cache_en, mmu_en, flush, req_valid, req_cacheable;
    logic [31:0] req_addr;
    logic        rsp_ready;
    logic [31:0] rsp_data;
    logic        mem_req_valid;
    logic [26:0] mem_req_line;
    logic [2:0]  mem_req_word;
    logic        mem_req_buf;
    logic        mem_rsp_valid, mem_rsp_buf;
    logic [2:0]  mem_rsp_idx;
    logic [31:0] mem_rsp_data;

    int   n_chk = 0;
    int   n_fail = 0;
    logic last_buf;

    always #4 clk = ~clk;

    ifb_icache dut_i (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .mmu_en(mmu_en), .flush(flush),
        .req_valid(req_valid), .req_addr(req_addr), .req_cacheable(req_cacheable),
        .rsp_ready(rsp_ready), .rsp_data(rsp_data), .mem_req_valid(mem_req_valid),
        .mem_req_line(mem_req_line), .mem_req_word(mem_req_word), .mem_req_buf(mem_req_buf),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_buf(mem_rsp_buf), .mem_rsp_idx(mem_rsp_idx),
        .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [31:0] mk(input logic [21:0] tg, input logic [4:0] st, input logic [2:0] wd);
        return {tg, st, wd, 2'b00};
    endfunction

    function automatic logic [31:0] memf(input logic [26:0] ln, input logic [2:0] ix);
        logic [31:0] v;
        v = {2'b00, ln, ix};
        return (v * 32'h0001_0003) ^ 32'h5A5A_A5A5;
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fetch(input string what, input logic [31:0] a, input bit exp_hit, input bit exp_req);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        #1;
        check({what, " ready"}, 32'(rsp_ready), 32'(exp_hit));
        if (exp_hit) check({what, " data"}, rsp_data, memf(a[31:5], a[4:2]));
        check({what, " memreq"}, 32'(mem_req_valid), 32'(exp_req));
        if (exp_req && mem_req_valid) begin
            check({what, " R2 line"}, 32'(mem_req_line), 32'(a[31:5]));
            check({what, " R2 word"}, 32'(mem_req_word), 32'(a[4:2]));
            last_buf = mem_req_buf;
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic word_in(input logic b, input logic [26:0] ln, input logic [2:0] ix);
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_buf   = b;
        mem_rsp_idx   = ix;
        mem_rsp_data  = memf(ln, ix);
        @(posedge clk);
        #1 mem_rsp_valid = 1'b0;
    endtask

    task automatic fill(input logic b, input logic [31:0] a, input int n);
        for (int k = 0; k < n; k++) word_in(b, a[31:5], 3'(a[4:2] + 3'(k)));
        idle(2);
    endtask

    task automatic load(input string what, input logic [31:0] a);
        logic b;
        fetch({what, " miss"}, a, 1'b0, 1'b1);
        b = last_buf;
        fill(b, a, 8);
        fetch({what, " filled"}, a, 1'b1, 1'b0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        #1;
        check("R1 idle ready", 32'(rsp_ready), 0);
        check("R1 idle memreq", 32'(mem_req_valid), 0);
    endtask

    task automatic t_partial;
        logic [31:0] a;
        logic        b;
        a = mk(22'd1, 5'd0, 3'd5);
        fetch("R1 R3 first miss", a, 1'b0, 1'b1);
        b = last_buf;
        fetch("R3 pending line no request", a, 1'b0, 1'b0);
        word_in(b, a[31:5], 3'd5);
        fetch("R4 critical word served", a, 1'b1, 1'b0);
        fetch("R4 absent word waits", mk(22'd1, 5'd0, 3'd6), 1'b0, 1'b0);
        word_in(b, a[31:5], 3'd6);
        fetch("R4 second word served", mk(22'd1, 5'd0, 3'd6), 1'b1, 1'b0);
        for (int k = 0; k < 6; k++) word_in(b, a[31:5], 3'(3'd7 + 3'(k)));
        idle(2);
        fetch("R4 wrapped word served", mk(22'd1, 5'd0, 3'd0), 1'b1, 1'b0);
    endtask

    task automatic t_two_outstanding;
        logic [31:0] ab, ac, ad;
        logic        bb, bc, bd;
        ab = mk(22'd2, 5'd1, 3'd2);
        ac = mk(22'd3, 5'd2, 3'd0);
        ad = mk(22'd4, 5'd3, 3'd7);
        fetch("R6 miss B", ab, 1'b0, 1'b1);
        bb = last_buf;
        fetch("R6 miss C", ac, 1'b0, 1'b1);
        bc = last_buf;
        check("R6 distinct buffers", 32'(bb != bc), 1);
        fetch("R7 third miss stalls", ad, 1'b0, 1'b0);
        fill(bb, ab, 8);
        fetch("R7 third miss after retire", ad, 1'b0, 1'b1);
        bd = last_buf;
        check("R7 freed buffer reused", 32'(bd), 32'(bb));
        fill(bc, ac, 8);
        fill(bd, ad, 8);
        fetch("R5 R8 line A from cache", mk(22'd1, 5'd0, 3'd3), 1'b1, 1'b0);
        fetch("R8 line B from cache", ab, 1'b1, 1'b0);
    endtask

    task automatic t_cacheable;
        logic [31:0] ae, ah;
        ae = mk(22'd5, 5'd4, 3'd1);
        ah = mk(22'd8, 5'd8, 3'd4);
        req_cacheable = 1'b0;
        load("R9 noncacheable E", ae);
        req_cacheable = 1'b1;
        load("R9 F", mk(22'd6, 5'd5, 3'd0));
        load("R9 G", mk(22'd7, 5'd6, 3'd0));
        fetch("R9 E not cached", ae, 1'b0, 1'b1);
        fill(last_buf, ae, 8);
        mmu_en = 1'b0;
        req_cacheable = 1'b0;
        load("R8 mmu off H", ah);
        mmu_en = 1'b1;
        req_cacheable = 1'b1;
        load("R8 I1", mk(22'd9, 5'd9, 3'd0));
        load("R8 I2", mk(22'd10, 5'd10, 3'd0));
        fetch("R8 H cached with mmu off", ah, 1'b1, 1'b0);
    endtask

    task automatic t_disabled;
        logic [31:0] aj;
        aj = mk(22'd11, 5'd11, 3'd3);
        cache_en = 1'b0;
        fetch("R10 old line hits", mk(22'd1, 5'd0, 3'd2), 1'b1, 1'b0);
        load("R10 J", aj);
        fetch("R10 J backward", mk(22'd11, 5'd11, 3'd0), 1'b1, 1'b0);
        fetch("R10 J forward", mk(22'd11, 5'd11, 3'd7), 1'b1, 1'b0);
        load("R10 K", mk(22'd12, 5'd12, 3'd0));
        load("R10 L", mk(22'd13, 5'd13, 3'd0));
        fetch("R10 J never written", aj, 1'b0, 1'b1);
        fill(last_buf, aj, 8);
        cache_en = 1'b1;
    endtask

    task automatic t_round_robin;
        for (int t = 0; t < 5; t++) load("R11 fill set 7", mk(22'(20 + t), 5'd7, 3'd0));
        fetch("R11 second line kept", mk(22'd21, 5'd7, 3'd1), 1'b1, 1'b0);
        fetch("R11 third line kept", mk(22'd22, 5'd7, 3'd1), 1'b1, 1'b0);
        fetch("R11 first line evicted", mk(22'd20, 5'd7, 3'd1), 1'b0, 1'b1);
        fill(last_buf, mk(22'd20, 5'd7, 3'd1), 8);
    endtask

    task automatic t_flush;
        logic [31:0] a;
        a = mk(22'd1, 5'd0, 3'd4);
        fetch("R12 before flush", a, 1'b1, 1'b0);
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        #1 flush = 1'b0;
        fetch("R12 after flush misses", a, 1'b0, 1'b1);
        fill(last_buf, a, 8);
        fetch("R12 refilled", a, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cache_en = 1'b1;
        mmu_en = 1'b1;
        flush = 1'b0;
        req_valid = 1'b0;
        req_addr = '0;
        req_cacheable = 1'b1;
        mem_rsp_valid = 1'b0;
        mem_rsp_buf = 1'b0;
        mem_rsp_idx = '0;
        mem_rsp_data = '0;
        last_buf = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_partial();
        t_two_outstanding();
        t_cacheable();
        t_disabled();
        t_round_robin();
        t_flush();
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule